// File: doc/BRIEF.md
# Programmable Display Clock Divider Tree

This block turns one fast VCO clock into two slower display clocks: a byte clock and a pixel clock. Both are produced as registered levels in the VCO domain. The byte path runs through a power-of-two output divider, then a one-based bit-clock divider, then a fixed /8 stage. The pixel path takes one of four taps from the middle of that chain. The taps are the bit clock, half the bit clock, the output-divider clock, and a quarter of the output-divider clock. A one-based pixel divider follows the tap.

Software programs the tree through a simple register-write port with two 8-bit configuration registers. Those registers hold the divider fields, the tap select and a global clock enable. Each output divider holds its active ratio and enable until its current period has run out, at the end of the low phase. Reprogramming and gating therefore never produce a runt pulse. Each period starts with the high phase.

Top module: `dclk_tree`

## Requirements
- R1: After reset both registers are zero, the clock enable is off, and `byte_clk_o` and `pix_clk_o` are low.
- R2: Writing with `cfg_addr`=0 sets the register that holds the bit divider in data bits [3:0] and the pixel divider in bits [7:4]. Writing with `cfg_addr`=1 sets the register that holds the pixel tap select in bits [1:0], the output-divider exponent in bits [5:4] and the clock enable in bit 7. Bits 3, 2 and 6 of that register are ignored.
- R3: The output divider divides by 2 to the power of the exponent field (1, 2, 4 or 8). The byte clock period is 8 × output ratio × bit ratio VCO cycles.
- R4: A bit divider field of N divides by N. A value of 0 divides by 1.
- R5: Tap select 0 picks the bit clock, 1 picks the bit clock /2, 2 picks the output-divider clock and 3 picks the output-divider clock /4.
- R6: A pixel divider field of N divides the selected tap by N, and 0 divides by 1. The pixel period is the tap ratio × the pixel ratio, in VCO cycles.
- R7: For a total ratio T of 2 or more, each period is high for floor(T/2) cycles and then low for the rest, so odd ratios are one cycle shorter high than low. For T=1 the output stays high while it is enabled.
- R8: A change to a divider field or to the tap select does not alter the period in progress. The new ratio starts with the next period, after the current low phase ends.
- R9: Clearing the enable lets the high pulse in progress finish, and the output is then held low. Setting the enable from the idle state drives the output high on the second clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast source clock that clocks all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 holds the dividers, 1 holds the tap, exponent and enable |
| cfg_data | input | 8 | Write data |
| byte_clk_o | output | 1 | Byte clock level |
| pix_clk_o | output | 1 | Pixel clock level |

## Verification
A wrong ratio register, counter or tap decode shows up at the ports as a wrong period or a wrong high-phase length. It is visible within the first full period after the configuration settles, and the bench measures both in VCO cycles. A reload at the wrong moment shows a different fault. It changes the length of the period that was in progress when the write landed, or it cuts a high pulse short when the enable is cleared, so it is caught on the very next edge of the output. An enable path that is held or lost shows as an output that keeps toggling after gating, or that fails to rise on the second edge after re-enable.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

   // register geometry
   localparam int unsigned REG_W    = 8;
   localparam int unsigned DIV_W    = 4;
   localparam int unsigned ODIV_W   = 2;
   localparam int unsigned SEL_W    = 2;
   localparam int unsigned ODIV_LSB = 4;
   localparam int unsigned EN_BIT   = 7;

   // pixel tap order; the encoding is behaviour
   typedef enum logic [SEL_W-1:0] {
      TAP_BIT      = 2'd0,
      TAP_BIT_HALF = 2'd1,
      TAP_ODIV     = 2'd2,
      TAP_ODIV_QTR = 2'd3
   } pix_tap_e;

   typedef struct packed {
      logic             clk_en;
      logic [ODIV_W-1:0] odiv_exp;
      pix_tap_e         pix_sel;
      logic [DIV_W-1:0] pix_div;
      logic [DIV_W-1:0] bit_div;
   } dclk_cfg_t;

   // one-based field: zero behaves as one
   function automatic logic [DIV_W-1:0] one_based(input logic [DIV_W-1:0] f);
      return (f == '0) ? DIV_W'(1) : f;
   endfunction

endpackage

// File: rtl/dclk_cfg_regs.sv
module dclk_cfg_regs
   import dclk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             addr,
   input  logic [REG_W-1:0] wdata,
   output dclk_cfg_t        cfg
);

   // elaboration-time layout checks
   if (2 * DIV_W > REG_W) begin : g_bad_div
      $error("divider fields do not fit the register");
   end
   if (ODIV_LSB < SEL_W || ODIV_LSB + ODIV_W > EN_BIT || EN_BIT >= REG_W) begin : g_bad_r1
      $error("second register fields overlap");
   end

   // bits of the second register that carry no field
   logic unused_bits;
   assign unused_bits = ^{wdata[ODIV_LSB-1:SEL_W], wdata[EN_BIT-1:ODIV_LSB+ODIV_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr) begin
         if (!addr) begin
            cfg.bit_div <= wdata[DIV_W-1:0];
            cfg.pix_div <= wdata[2*DIV_W-1:DIV_W];
         end else begin
            cfg.pix_sel  <= pix_tap_e'(wdata[SEL_W-1:0]);
            cfg.odiv_exp <= wdata[ODIV_LSB +: ODIV_W];
            cfg.clk_en   <= wdata[EN_BIT];
         end
      end
   end

endmodule

// File: rtl/dclk_ratio_calc.sv
module dclk_ratio_calc
   import dclk_pkg::*;
#(
   parameter int unsigned CNT_W      = 12,
   parameter int unsigned BYTE_RATIO = 8,
   parameter int unsigned HALF_TAP   = 2,
   parameter int unsigned QTR_TAP    = 4
) (
   input  dclk_cfg_t        cfg,
   output logic [CNT_W-1:0] byte_ratio,
   output logic [CNT_W-1:0] pix_ratio
);

   localparam logic [CNT_W-1:0] BYTE_K = CNT_W'(BYTE_RATIO);
   localparam logic [CNT_W-1:0] HALF_K = CNT_W'(HALF_TAP);
   localparam logic [CNT_W-1:0] QTR_K  = CNT_W'(QTR_TAP);

   logic [CNT_W-1:0] odiv_r, bdiv_r, pdiv_r, bit_r, tap_r;

   always_comb begin
      odiv_r = CNT_W'(1) << cfg.odiv_exp;
      bdiv_r = CNT_W'(one_based(cfg.bit_div));
      pdiv_r = CNT_W'(one_based(cfg.pix_div));
      bit_r  = odiv_r * bdiv_r;
      unique case (cfg.pix_sel)
         TAP_BIT:      tap_r = bit_r;
         TAP_BIT_HALF: tap_r = bit_r * HALF_K;
         TAP_ODIV:     tap_r = odiv_r;
         default:      tap_r = odiv_r * QTR_K;
      endcase
      byte_ratio = bit_r * BYTE_K;
      pix_ratio  = tap_r * pdiv_r;
   end

endmodule

// File: rtl/dclk_out_div.sv
module dclk_out_div #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] ratio_in,
   input  logic             en_in,
   output logic             clk_out
);

   logic [CNT_W-1:0] cnt, act_ratio;
   logic             act_en;
   logic [CNT_W-1:0] nxt_cnt, nxt_ratio;
   logic             nxt_en, reload;

   // a period ends on its last low cycle; only then may settings change
   always_comb begin
      reload    = !act_en || (cnt == act_ratio - CNT_W'(1));
      nxt_cnt   = reload ? '0 : cnt + CNT_W'(1);
      nxt_ratio = reload ? ratio_in : act_ratio;
      nxt_en    = reload ? en_in : act_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         act_ratio <= CNT_W'(1);
         act_en    <= 1'b0;
         clk_out   <= 1'b0;
      end else begin
         cnt       <= nxt_cnt;
         act_ratio <= nxt_ratio;
         act_en    <= nxt_en;
         clk_out   <= nxt_en && ((nxt_ratio == CNT_W'(1)) || (nxt_cnt < (nxt_ratio >> 1)));
      end
   end

endmodule

// File: rtl/dclk_tree.sv
module dclk_tree
   import dclk_pkg::*;
#(
   parameter int unsigned BYTE_RATIO = 8,
   parameter int unsigned HALF_TAP   = 2,
   parameter int unsigned QTR_TAP    = 4
) (
   input  logic             vco_clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             cfg_addr,
   input  logic [REG_W-1:0] cfg_data,
   output logic             byte_clk_o,
   output logic             pix_clk_o
);

   localparam int unsigned MAX_ODIV  = 1 << ((1 << ODIV_W) - 1);
   localparam int unsigned MAX_DIV   = (1 << DIV_W) - 1;
   localparam int unsigned MAX_BYTE  = BYTE_RATIO * MAX_ODIV * MAX_DIV;
   localparam int unsigned TAP_A     = HALF_TAP * MAX_ODIV * MAX_DIV;
   localparam int unsigned TAP_B     = QTR_TAP * MAX_ODIV;
   localparam int unsigned MAX_TAP   = (TAP_A > TAP_B) ? TAP_A : TAP_B;
   localparam int unsigned MAX_PIX   = MAX_TAP * MAX_DIV;
   localparam int unsigned MAX_RATIO = (MAX_BYTE > MAX_PIX) ? MAX_BYTE : MAX_PIX;
   localparam int unsigned CNT_W     = $clog2(MAX_RATIO + 1);
   localparam int unsigned N_OUT     = 2;

   if (BYTE_RATIO < 2 || HALF_TAP < 2 || QTR_TAP < 2) begin : g_bad_fixed
      $error("fixed divider stages must divide by two or more");
   end

   dclk_cfg_t        cfg_q;
   logic             glb_en;
   logic [CNT_W-1:0] byte_ratio, pix_ratio;
   logic [CNT_W-1:0] ratio_arr [N_OUT];
   logic [N_OUT-1:0] out_arr;

   assign glb_en = cfg_q.clk_en;

   dclk_cfg_regs u_regs (
      .clk   (vco_clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .addr  (cfg_addr),
      .wdata (cfg_data),
      .cfg   (cfg_q)
   );

   dclk_ratio_calc #(
      .CNT_W      (CNT_W),
      .BYTE_RATIO (BYTE_RATIO),
      .HALF_TAP   (HALF_TAP),
      .QTR_TAP    (QTR_TAP)
   ) u_ratio (
      .cfg        (cfg_q),
      .byte_ratio (byte_ratio),
      .pix_ratio  (pix_ratio)
   );

   assign ratio_arr[0] = byte_ratio;
   assign ratio_arr[1] = pix_ratio;

   for (genvar i = 0; i < N_OUT; i++) begin : g_div
      dclk_out_div #(.CNT_W(CNT_W)) u_div (
         .clk      (vco_clk),
         .rst_n    (rst_n),
         .ratio_in (ratio_arr[i]),
         .en_in    (glb_en),
         .clk_out  (out_arr[i])
      );
   end

   assign byte_clk_o = out_arr[0];
   assign pix_clk_o  = out_arr[1];

endmodule

// File: rtl/dclk_tree_chk.sv
module dclk_tree_chk #(
   parameter int unsigned MIN_PHASE = 4
) (
   input logic vco_clk,
   input logic rst_n,
   input logic clk_en,
   input logic byte_clk,
   input logic pix_clk
);

   logic [15:0] hi_run, lo_run;
   logic        seen_fall;

   always_ff @(posedge vco_clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run    <= '0;
         lo_run    <= '0;
         seen_fall <= 1'b0;
      end else begin
         if (byte_clk) begin
            hi_run <= (hi_run != '1) ? hi_run + 16'd1 : hi_run;
            lo_run <= '0;
         end else begin
            lo_run <= (lo_run != '1) ? lo_run + 16'd1 : lo_run;
            hi_run <= '0;
         end
         if (!byte_clk && hi_run != '0) seen_fall <= 1'b1;
      end
   end

   // R9
   gate_pix_low_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
      (!pix_clk && !clk_en) |=> !pix_clk);

   // R9
   gate_byte_low_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
      (!byte_clk && !clk_en) |=> !byte_clk);

   // R7
   byte_hi_min_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
      $fell(byte_clk) |-> (hi_run >= 16'(MIN_PHASE)));

   // R8
   byte_lo_min_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
      ($rose(byte_clk) && seen_fall) |-> (lo_run >= 16'(MIN_PHASE)));

endmodule

bind dclk_tree dclk_tree_chk #(.MIN_PHASE(BYTE_RATIO / 2)) u_chk (
   .vco_clk  (vco_clk),
   .rst_n    (rst_n),
   .clk_en   (glb_en),
   .byte_clk (byte_clk_o),
   .pix_clk  (pix_clk_o)
);

// File: tb/dclk_tree_tb.sv
module dclk_tree_tb;

   localparam int CLK_HALF = 5;
   localparam int WDOG     = 150000;
   localparam int SETTLE   = 700;

   logic       vco_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic       cfg_wr  = 1'b0;
   logic       cfg_addr = 1'b0;
   logic [7:0] cfg_data = 8'h00;
   logic       byte_clk_o, pix_clk_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   typedef struct {
      int    sel;     // 0 byte, 1 pixel
      int    per;
      int    hi;
      bit    hionly;
      bit    started;
      string req;
   } item_t;

   item_t sb[$];

   dclk_tree u_dut (
      .vco_clk    (vco_clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_addr   (cfg_addr),
      .cfg_data   (cfg_data),
      .byte_clk_o (byte_clk_o),
      .pix_clk_o  (pix_clk_o)
   );

   always #CLK_HALF vco_clk = ~vco_clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge vco_clk);
         cyc++;
         if (cyc > WDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            finish_run();
         end
      end
   end

   // monitor: measures output periods and pops scoreboard items
   initial begin
      bit prev [2];
      bit cur  [2];
      int hcnt [2];
      int lcnt [2];
      for (int s = 0; s < 2; s++) begin
         prev[s] = 1'b0; hcnt[s] = 0; lcnt[s] = 0;
      end
      forever begin
         @(negedge vco_clk);
         cur[0] = byte_clk_o;
         cur[1] = pix_clk_o;
         for (int s = 0; s < 2; s++) begin
            if (cur[s] && !prev[s]) begin
               if (sb.size() > 0 && sb[0].sel == s && sb[0].started && !sb[0].hionly) begin
                  chk(hcnt[s] + lcnt[s] == sb[0].per, {sb[0].req, " period"}, hcnt[s] + lcnt[s], sb[0].per);
                  chk(hcnt[s] == sb[0].hi, {sb[0].req, " high"}, hcnt[s], sb[0].hi);
                  void'(sb.pop_front());
               end
               if (sb.size() > 0 && sb[0].sel == s && !sb[0].started) sb[0].started = 1'b1;
               hcnt[s] = 1;
               lcnt[s] = 0;
            end else if (!cur[s] && prev[s]) begin
               if (sb.size() > 0 && sb[0].sel == s && sb[0].started && sb[0].hionly) begin
                  chk(hcnt[s] == sb[0].hi, {sb[0].req, " high"}, hcnt[s], sb[0].hi);
                  void'(sb.pop_front());
               end
               lcnt[s] = 1;
            end else if (cur[s]) begin
               hcnt[s]++;
            end else begin
               lcnt[s]++;
            end
            prev[s] = cur[s];
         end
      end
   end

   task automatic wr(input bit a, input logic [7:0] d);
      @(negedge vco_clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_data = d;
      @(negedge vco_clk);
      cfg_wr = 1'b0;
   endtask

   task automatic settle();
      repeat (SETTLE) @(negedge vco_clk);
   endtask

   task automatic push(input int sel, input int per, input int hi, input bit hionly, input string req);
      item_t it;
      it.sel = sel; it.per = per; it.hi = hi; it.hionly = hionly; it.started = 1'b0; it.req = req;
      sb.push_back(it);
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge vco_clk);
   endtask

   task automatic wait_started();
      while (!(sb.size() > 0 && sb[0].started)) @(negedge vco_clk);
   endtask

   task automatic expect_both(input int bper, input int pper, input string req);
      push(0, bper, bper / 2, 1'b0, req);
      push(1, pper, pper / 2, 1'b0, req);
      drain();
   endtask

   initial begin
      int lows;
      int highs;
      repeat (3) @(negedge vco_clk);
      rst_n = 1'b1;

      // R1: outputs low out of reset
      lows = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge vco_clk);
         if (!byte_clk_o && !pix_clk_o) lows++;
      end
      chk(lows == 20, "R1 reset outputs low", lows, 20);

      // R7 odd ratio: bit /1, pixel tap0 /3 -> byte 8, pix 3 (high 1)
      wr(0, 8'h31); wr(1, 8'h80); settle();
      expect_both(8, 3, "R7 odd ratio");

      // R3 R4 R5: exponent 3, bit /5, tap1, pixel /2 -> byte 320, pix 160
      wr(0, 8'h25); wr(1, 8'hB1); settle();
      expect_both(320, 160, "R3 R5 tap1");

      // R4 R6: zero fields act as one; exponent 1, tap2 -> byte 16, pix 2
      wr(0, 8'h00); wr(1, 8'h92); settle();
      expect_both(16, 2, "R4 R6 zero fields");

      // R5 R6: exponent 2, bit /7, tap3, pixel /5 -> byte 224, pix 80
      wr(0, 8'h57); wr(1, 8'hA3); settle();
      expect_both(224, 80, "R5 R6 tap3");

      // R7: total ratio 1 on pixel path holds it high
      wr(0, 8'h11); wr(1, 8'h82); settle();
      highs = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge vco_clk);
         if (pix_clk_o) highs++;
      end
      chk(highs == 20, "R7 ratio one held high", highs, 20);
      push(0, 8, 4, 1'b0, "R3 byte min ratio"); drain();

      // R5 tap0: exponent 1, bit /3, pixel /7 -> byte 48, pix 42
      wr(0, 8'h73); wr(1, 8'h90); settle();
      expect_both(48, 42, "R5 tap0");

      // R2: reserved bits 6,3,2 set are ignored -> byte 32, pix 24
      wr(0, 8'h32); wr(1, 8'hDD); settle();
      expect_both(32, 24, "R2 ignored bits");

      // R8: pixel divider change mid-high; old period completes
      push(1, 24, 12, 1'b0, "R8 pix old period");
      wait_started();
      wr(0, 8'h12);
      push(1, 8, 4, 1'b0, "R8 pix new period");
      drain();

      // R8: bit divider change mid-high on byte path
      push(0, 32, 16, 1'b0, "R8 byte old period");
      wait_started();
      wr(0, 8'h14);
      push(0, 64, 32, 1'b0, "R8 byte new period");
      drain();
      push(1, 16, 8, 1'b0, "R8 pix after change"); drain();

      // R9: clear enable mid-high; pulse finishes, then outputs stay low
      push(1, 0, 8, 1'b1, "R9 gate full pulse");
      wait_started();
      wr(1, 8'h11);
      drain();
      repeat (100) @(negedge vco_clk);
      lows = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge vco_clk);
         if (!byte_clk_o && !pix_clk_o) lows++;
      end
      chk(lows == 50, "R9 gated low", lows, 50);

      // R9: re-enable timing
      @(negedge vco_clk);
      cfg_wr = 1'b1; cfg_addr = 1'b1; cfg_data = 8'h91;
      @(negedge vco_clk);
      cfg_wr = 1'b0;
      chk(!pix_clk_o, "R9 low one edge after write", int'(pix_clk_o), 0);
      @(negedge vco_clk);
      chk(pix_clk_o && byte_clk_o, "R9 high two edges after write", int'(pix_clk_o && byte_clk_o), 1);
      expect_both(64, 16, "R9 resumed");

      finish_run();
   end

endmodule